// File: doc/BRIEF.md
# Complement-Retry Adder Checker

This block wraps a single k-bit binary adder and checks it by running every addition twice on the same hardware. A binary adder with both operands and the carry-in as inputs, and the sum bits plus carry-out as outputs, is a self-dual function. If every input is inverted, every output comes back inverted. The block relies on that property to detect faults in the adder.

A request is accepted through a start/ready handshake, and the operands are latched at that moment. In the first cycle the adder sees the true operands and carry-in, and its k+1 outputs are stored. In the second cycle the same adder sees the bitwise inverse of all of its inputs. Each stored bit is then paired with its second-cycle counterpart. A healthy pair always disagrees, so each pair is combined with XNOR, and any pair that produces a 1 raises the error flag. A line stuck at 0 or 1 gives the same value in both passes and is therefore always caught; many transient upsets are caught too. The reported sum and carry-out are those of the true-input pass.

A test-only injection input can force one chosen adder output line to a fixed value, so that detection can be shown. The controller is a four-state machine:
- IDLE waits with ready high.
- PASS_TRUE is the first busy cycle.
- PASS_INV is the second busy cycle.
- REPORT pulses done for one cycle with ready high.

The transitions are:
- IDLE goes to PASS_TRUE on start.
- PASS_TRUE always goes to PASS_INV.
- PASS_INV always goes to REPORT.
- REPORT goes to PASS_TRUE on start, and otherwise to IDLE.

Top module: `alt_adder_checker`

## Requirements
- R1: While reset is held and immediately after it, ready is 1 and busy, done, error, sum and carry-out are 0.
- R2: A start seen at a clock edge while ready is 1 is accepted. Busy is then 1 for exactly the next two cycles, and done is 1 for exactly one cycle after that.
- R3: With no injection, {carry-out, sum} reported at done equals a + b + carry-in of the operands latched when start was accepted.
- R4: With no injection, the error flag at done is 0 for every operand pattern, including all-zero and all-one inputs, because the inverted-input pass yields the exact inverse of the true pass.
- R5: The error flag is the OR of the XNOR of each of the k+1 true-pass output bits with its inverted-pass counterpart. A stuck value injected on any sum line or on the carry-out line for the whole operation sets the error flag to 1, whatever the operands.
- R6: Start is ignored while busy is 1. The operands in use are not replaced, the result matches the original request, and no extra done follows.
- R7: A start seen in the done cycle is accepted at once, so operations can run back to back, one every three cycles.
- R8: The injection index selects sum bit i for values 0 to k-1 and the carry-out for value k. When injection is enabled, the selected line reads the injection value in both passes, and the reported result shows that forced bit. An index above k has no effect.
- R9: Sum, carry-out and error keep their values from one done until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request an addition |
| op_a_i | input | WIDTH | First operand |
| op_b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry-in |
| inj_en_i | input | 1 | Test only: enable stuck-line injection |
| inj_idx_i | input | IDXW | Test only: line to force (0..WIDTH-1 sum, WIDTH carry-out) |
| inj_val_i | input | 1 | Test only: forced value |
| ready_o | output | 1 | Block can accept start this cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| sum_o | output | WIDTH | Sum from the true-input pass |
| carry_o | output | 1 | Carry-out from the true-input pass |
| err_o | output | 1 | Mismatch seen between the two passes |

## Verification
The assertions on detection assume that the injection controls keep one value across both passes of an operation. The property that a forced line raises the error only applies when enable, index and value are equal in the true and inverted cycles. The property that a clean run reports no error only applies when injection is off in both of those cycles. The stimulus sets the injection fields together with the operands, before start, and leaves them unchanged until done has been observed. Extra start pulses are issued only in busy or done cycles, and only on purpose, to exercise the ignore and back-to-back rules.

// File: rtl/alc_pkg.sv
package alc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PASS_TRUE = 2'd1,
        ST_PASS_INV  = 2'd2,
        ST_REPORT    = 2'd3
    } alc_state_e;
endpackage

// File: rtl/alc_fsm.sv
module alc_fsm
    import alc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output alc_state_e state_o,
    output logic       accept_o,
    output logic       ready_o,
    output logic       busy_o,
    output logic       done_o
);
    alc_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_PASS_TRUE;
            ST_PASS_TRUE: state_d = ST_PASS_INV;
            ST_PASS_INV:  state_d = ST_REPORT;
            ST_REPORT:    state_d = start_i ? ST_PASS_TRUE : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs from the state
    always_comb begin
        ready_o = 1'b0;
        busy_o  = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:      ready_o = 1'b1;
            ST_PASS_TRUE: busy_o  = 1'b1;
            ST_PASS_INV:  busy_o  = 1'b1;
            ST_REPORT:    begin ready_o = 1'b1; done_o = 1'b1; end
            default:      ready_o = 1'b0;
        endcase
        accept_o = ready_o & start_i;
        state_o  = state_q;
    end

    // R2: two busy cycles, then one done cycle
    assert_true_then_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS_TRUE) |=> (state_q == ST_PASS_INV));
    assert_inv_then_report_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS_INV) |=> (state_q == ST_REPORT));
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6: a busy cycle never offers ready
    assert_no_ready_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !ready_o);
    // R7: start in the report cycle begins a new operation
    assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> busy_o);
endmodule

// File: rtl/alc_operand_mux.sv
module alc_operand_mux #(
    parameter int WIDTH = 8
) (
    input  logic             invert_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] a_o,
    output logic [WIDTH-1:0] b_o,
    output logic             c_o
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            assign a_o[g] = a_i[g] ^ invert_i;
            assign b_o[g] = b_i[g] ^ invert_i;
        end
    endgenerate
    assign c_o = c_i ^ invert_i;
endmodule

// File: rtl/alc_adder.sv
module alc_adder #(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_i,
    input  logic             inj_en_i,
    input  logic [IDXW-1:0]  inj_idx_i,
    input  logic             inj_val_i,
    output logic [WIDTH:0]   res_o
);
    logic [WIDTH:0] raw;

    always_comb raw = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};

    // stuck-line injection on output bit g (WIDTH is carry-out)
    genvar g;
    generate
        for (g = 0; g <= WIDTH; g++) begin : g_line
            assign res_o[g] = (inj_en_i && (inj_idx_i == IDXW'(g))) ? inj_val_i : raw[g];
        end
    endgenerate
endmodule

// File: rtl/alc_compare.sv
module alc_compare #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0] first_i,
    input  logic [WIDTH:0] second_i,
    output logic           mismatch_o
);
    logic [WIDTH:0] same;
    genvar g;
    generate
        for (g = 0; g <= WIDTH; g++) begin : g_pair
            assign same[g] = first_i[g] ~^ second_i[g];
        end
    endgenerate
    assign mismatch_o = |same;
endmodule

// File: rtl/alt_adder_checker.sv
module alt_adder_checker
    import alc_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic             carry_i,
    input  logic             inj_en_i,
    input  logic [IDXW-1:0]  inj_idx_i,
    input  logic             inj_val_i,
    output logic             ready_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             err_o
);
    alc_state_e     state;
    logic           accept;
    logic [WIDTH-1:0] opa_q, opb_q;
    logic           cin_q;
    logic [WIDTH-1:0] add_a, add_b;
    logic           add_c;
    logic [WIDTH:0] add_res;
    logic [WIDTH:0] first_q;
    logic           mismatch;
    logic [WIDTH-1:0] sum_q;
    logic           carry_q, err_q;

    alc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .state_o (state),
        .accept_o(accept),
        .ready_o (ready_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    // operand latch, loaded only when start is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
            cin_q <= 1'b0;
        end else if (accept) begin
            opa_q <= op_a_i;
            opb_q <= op_b_i;
            cin_q <= carry_i;
        end
    end

    alc_operand_mux #(.WIDTH(WIDTH)) u_mux (
        .invert_i(state == ST_PASS_INV),
        .a_i     (opa_q),
        .b_i     (opb_q),
        .c_i     (cin_q),
        .a_o     (add_a),
        .b_o     (add_b),
        .c_o     (add_c)
    );

    alc_adder #(.WIDTH(WIDTH)) u_add (
        .a_i      (add_a),
        .b_i      (add_b),
        .c_i      (add_c),
        .inj_en_i (inj_en_i),
        .inj_idx_i(inj_idx_i),
        .inj_val_i(inj_val_i),
        .res_o    (add_res)
    );

    alc_compare #(.WIDTH(WIDTH)) u_cmp (
        .first_i   (first_q),
        .second_i  (add_res),
        .mismatch_o(mismatch)
    );

    // pass results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            sum_q   <= '0;
            carry_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (state == ST_PASS_TRUE) first_q <= add_res;
            if (state == ST_PASS_INV) begin
                sum_q   <= first_q[WIDTH-1:0];
                carry_q <= first_q[WIDTH];
                err_q   <= mismatch;
            end
        end
    end

    assign sum_o   = sum_q;
    assign carry_o = carry_q;
    assign err_o   = err_q;

    // R4: clean adder never flags
    assert_clean_no_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(inj_en_i, 1) && !$past(inj_en_i, 2)) |-> !err_o);
    // R5: a steady stuck line on a valid index is always caught
    assert_stuck_caught_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(inj_en_i, 1) && $past(inj_en_i, 2)
         && ($past(inj_idx_i, 1) == $past(inj_idx_i, 2))
         && ($past(inj_val_i, 1) == $past(inj_val_i, 2))
         && ($past(inj_idx_i, 1) <= IDXW'(WIDTH))) |-> err_o);
    // R6: operands do not change during the passes
    assert_operands_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS_TRUE) |=> ($stable(opa_q) && $stable(opb_q) && $stable(cin_q)));
    // R9: results only change as done appears
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || ($stable(sum_o) && $stable(carry_o) && $stable(err_o))));
endmodule

// File: tb/alt_adder_checker_tb.sv
`timescale 1ns/1ps
module alt_adder_checker_tb;
    localparam int W = 8;
    localparam int IW = $clog2(W + 1);
    localparam int NVEC = 10;
    // {a, b, cin, inj_en, inj_idx, inj_val}
    localparam logic [W+W+1+1+IW+1-1:0] VECS [NVEC] = '{
        {8'h00, 8'h00, 1'b0, 1'b0, 4'd0, 1'b0},
        {8'hFF, 8'hFF, 1'b1, 1'b0, 4'd0, 1'b0},
        {8'hA5, 8'h5A, 1'b0, 1'b0, 4'd0, 1'b0},
        {8'h7F, 8'h01, 1'b1, 1'b0, 4'd0, 1'b0},
        {8'hFF, 8'h00, 1'b1, 1'b0, 4'd0, 1'b0},
        {8'h3C, 8'hC3, 1'b0, 1'b1, 4'd0, 1'b1},
        {8'h12, 8'h34, 1'b1, 1'b1, 4'd8, 1'b0},
        {8'h55, 8'hAA, 1'b0, 1'b1, 4'd3, 1'b0},
        {8'h10, 8'h20, 1'b0, 1'b1, 4'd9, 1'b1},
        {8'h80, 8'h80, 1'b0, 1'b1, 4'd8, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] opa = '0, opb = '0;
    logic cin = 1'b0;
    logic inj_en = 1'b0;
    logic [IW-1:0] inj_idx = '0;
    logic inj_val = 1'b0;
    logic ready, busy, done, cout, err;
    logic [W-1:0] sum;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    alt_adder_checker #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .op_a_i(opa), .op_b_i(opb), .carry_i(cin),
        .inj_en_i(inj_en), .inj_idx_i(inj_idx), .inj_val_i(inj_val),
        .ready_o(ready), .busy_o(busy), .done_o(done),
        .sum_o(sum), .carry_o(cout), .err_o(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic c, input logic en,
                                         input logic [IW-1:0] idx, input logic v);
        logic [W:0] r;
        r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        if (en && idx <= IW'(W)) r[idx] = v;
        return r;
    endfunction

    // start at a falling edge, check through to done
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                          input logic en, input logic [IW-1:0] idx, input logic v);
        logic [W:0] e;
        e = model(a, b, c, en, idx, v);
        opa = a; opb = b; cin = c; inj_en = en; inj_idx = idx; inj_val = v;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2 busy cycle 1", busy, 1);
        @(negedge clk);
        chk("R2 busy cycle 2", busy, 1);
        @(negedge clk);
        chk("R2 done pulse", done, 1);
        chk("R2 busy low at done", busy, 0);
        chk("R3/R8 result", {cout, sum}, e);
        chk("R4/R5 error flag", err, (en && idx <= IW'(W)) ? 1 : 0);
        @(negedge clk);
        chk("R2 done single", done, 0);
        chk("R9 result held", {err, cout, sum}, {((en && idx <= IW'(W)) ? 1'b1 : 1'b0), e});
        inj_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W:0] e1, e2;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", ready, 1);
        chk("R1 quiet in reset", {busy, done, err, cout, sum}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", ready, 1);
        chk("R1 quiet after reset", {busy, done, err, cout, sum}, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_op(VECS[i][22:15], VECS[i][14:7], VECS[i][6], VECS[i][5],
                   VECS[i][4:1], VECS[i][0]);
        end

        // R6: start during busy is ignored
        e1 = model(8'h21, 8'h43, 1'b0, 1'b0, '0, 1'b0);
        opa = 8'h21; opb = 8'h43; cin = 1'b0; start = 1'b1;
        @(negedge clk);
        opa = 8'hEE; opb = 8'h77; cin = 1'b1;
        chk("R6 busy with start high", busy, 1);
        @(negedge clk);
        chk("R6 still busy", busy, 1);
        @(negedge clk);
        start = 1'b0;
        chk("R6 done", done, 1);
        chk("R6 result of first request", {cout, sum}, e1);
        @(negedge clk);
        chk("R6 no extra op", {busy, done}, 0);
        @(negedge clk);
        chk("R6 stays idle", {busy, done, ready}, 3'b001);

        // R7: back to back
        e1 = model(8'h0F, 8'hF1, 1'b1, 1'b0, '0, 1'b0);
        e2 = model(8'hC8, 8'h64, 1'b0, 1'b0, '0, 1'b0);
        opa = 8'h0F; opb = 8'hF1; cin = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 first done", done, 1);
        chk("R7 first result", {cout, sum}, e1);
        opa = 8'hC8; opb = 8'h64; cin = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R7 accepted in done cycle", busy, 1);
        @(negedge clk);
        @(negedge clk);
        chk("R7 second done", done, 1);
        chk("R7 second result", {err, cout, sum}, {1'b0, e2});

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule